// File: doc/BRIEF.md
# Processor Bus Address Router with Scratchpad Overlay

The router sits between a processor's native memory port and the targets in a small system. Each request carries an address, write data and byte strobes, and it is held until `cpu_ready` is seen. The address picks exactly one target: the scratchpad SRAM, the serial-flash read path, the flash configuration word, the two UART words, or the external user-peripheral port. The chosen target's ready and read data go back to the processor, and the readies and read data of every other target are ignored.

The lowest 16 MB window is shared. Addresses below the physical end of the scratchpad reach SRAM. Reads above that end and below 16 MB reach flash at the same 24-bit offset. Flash also appears unchanged in the second 16 MB window, so the processor can boot from 0x00100000, which is 1 MB into flash. Flash is read-only from this port. Writes to either flash window are answered by the router itself, so the bus does not stall. Addresses in the register page that match none of the three register words are answered the same way.

Top module: `soc_bus_router`

## Requirements
- R1: An address below SRAM_WORDS*4 selects SRAM for both reads and writes. `sram_word` carries address bits [SRAM_AW+1:2].
- R2: A read at an address from the SRAM end up to 0x00FFFFFF selects flash, and `flash_offset` equals address bits [23:0].
- R3: A read in 0x01000000–0x01FFFFFF selects flash with `flash_offset` equal to address bits [23:0], so the two windows give the same offset.
- R4: A write (any strobe bit set) to either flash window asserts no target valid. `cpu_ready` rises one cycle after the request appears and stays high for a single cycle, and `cpu_rdata` is 0.
- R5: Address 0x02000000 selects `cfg_valid`. Address 0x02000004 selects `uart_valid` with `uart_data_sel`=0 (divider word). Address 0x02000008 selects `uart_valid` with `uart_data_sel`=1 (data word).
- R6: Any other address in 0x02000000–0x02FFFFFF asserts no target valid and is answered like R4: ready one cycle later, read data 0.
- R7: Addresses 0x03000000 and above select `user_valid`, and `user_addr` equals the full address.
- R8: At most one target valid is high at a time. None is high without `cpu_valid`. `cpu_ready` follows only the selected target's ready, and the readies of unselected targets have no effect.
- R9: `cpu_rdata` equals the selected target's read data while that target is ready.
- R10: Out of reset, with no request, `cpu_ready` is low and no target valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_valid | input | 1 | Request present |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_wstrb | input | DATA_W/8 | Byte strobes, zero for a read |
| cpu_ready | output | 1 | Request completed |
| cpu_rdata | output | DATA_W | Read data returned |
| tgt_wdata | output | DATA_W | Write data to all targets |
| tgt_wstrb | output | DATA_W/8 | Byte strobes to all targets |
| sram_valid | output | 1 | SRAM selected |
| sram_word | output | SRAM_AW | SRAM word index |
| sram_ready | input | 1 | SRAM done |
| sram_rdata | input | DATA_W | SRAM read data |
| flash_valid | output | 1 | Flash read selected |
| flash_offset | output | FOFF_W | Byte offset into flash |
| flash_ready | input | 1 | Flash done |
| flash_rdata | input | DATA_W | Flash read data |
| cfg_valid | output | 1 | Flash config word selected |
| cfg_ready | input | 1 | Config word done |
| cfg_rdata | input | DATA_W | Config word read data |
| uart_valid | output | 1 | UART word selected |
| uart_data_sel | output | 1 | 0 divider word, 1 data word |
| uart_ready | input | 1 | UART done |
| uart_rdata | input | DATA_W | UART read data |
| user_valid | output | 1 | User peripheral selected |
| user_addr | output | ADDR_W | Full address to user port |
| user_ready | input | 1 | User port done |
| user_rdata | input | DATA_W | User port read data |

## Verification
The bench builds the router with its default parameters: a 256-word scratchpad and bases at 0x01000000, 0x02000000 and 0x03000000. With these values the overlay edge falls at 0x3FC/0x400, so both sides of it can be probed. The same values make the mirror pair 0x400/0x01000400, the top of the flash window and the unused words of the register page easy to reach. A phase in which every target holds its ready high shows that a router-answered access still takes its extra cycle, which means unselected readies are ignored.

// File: rtl/soc_bus_router.sv
module soc_bus_router #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SRAM_WORDS = 256,
  parameter logic [ADDR_W-1:0] FLASH_BASE = 32'h0100_0000,
  parameter logic [ADDR_W-1:0] REG_BASE   = 32'h0200_0000,
  parameter logic [ADDR_W-1:0] USER_BASE  = 32'h0300_0000,
  localparam int STRB_W = DATA_W / 8,
  localparam int SRAM_AW = $clog2(SRAM_WORDS),
  localparam int FOFF_W = $clog2(FLASH_BASE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [STRB_W-1:0] cpu_wstrb,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [DATA_W-1:0] tgt_wdata,
  output logic [STRB_W-1:0] tgt_wstrb,
  output logic              sram_valid,
  output logic [SRAM_AW-1:0] sram_word,
  input  logic              sram_ready,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic              flash_valid,
  output logic [FOFF_W-1:0] flash_offset,
  input  logic              flash_ready,
  input  logic [DATA_W-1:0] flash_rdata,
  output logic              cfg_valid,
  input  logic              cfg_ready,
  input  logic [DATA_W-1:0] cfg_rdata,
  output logic              uart_valid,
  output logic              uart_data_sel,
  input  logic              uart_ready,
  input  logic [DATA_W-1:0] uart_rdata,
  output logic              user_valid,
  output logic [ADDR_W-1:0] user_addr,
  input  logic              user_ready,
  input  logic [DATA_W-1:0] user_rdata
);

  localparam int WORD_LSB = $clog2(STRB_W);
  localparam logic [ADDR_W-1:0] SRAM_END = ADDR_W'(SRAM_WORDS * STRB_W);
  localparam logic [ADDR_W-1:0] DIV_ADDR = REG_BASE + ADDR_W'(STRB_W);
  localparam logic [ADDR_W-1:0] DAT_ADDR = REG_BASE + ADDR_W'(2 * STRB_W);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(STRB_W - 1);

  logic [ADDR_W-1:0] aligned;
  logic is_wr, in_low, in_sram, in_mirror, in_regs, in_user, flash_win;
  logic hit_cfg, hit_div, hit_dat, sink_hit, sink_ack_q;

  assign aligned   = cpu_addr & ALIGN_MASK;
  assign is_wr     = |cpu_wstrb;
  assign in_low    = cpu_addr < FLASH_BASE;
  assign in_sram   = cpu_addr < SRAM_END;
  assign in_mirror = (cpu_addr >= FLASH_BASE) && (cpu_addr < REG_BASE);
  assign in_regs   = (cpu_addr >= REG_BASE) && (cpu_addr < USER_BASE);
  assign in_user   = cpu_addr >= USER_BASE;
  assign flash_win = (in_low && !in_sram) || in_mirror;

  assign hit_cfg = in_regs && (aligned == REG_BASE);
  assign hit_div = in_regs && (aligned == DIV_ADDR);
  assign hit_dat = in_regs && (aligned == DAT_ADDR);

  assign tgt_wdata     = cpu_wdata;
  assign tgt_wstrb     = cpu_wstrb;
  assign sram_word     = cpu_addr[SRAM_AW+WORD_LSB-1:WORD_LSB];
  assign flash_offset  = cpu_addr[FOFF_W-1:0];
  assign user_addr     = cpu_addr;
  assign uart_data_sel = hit_dat;

  assign sram_valid  = cpu_valid && in_sram;
  assign flash_valid = cpu_valid && flash_win && !is_wr;
  assign cfg_valid   = cpu_valid && hit_cfg;
  assign uart_valid  = cpu_valid && (hit_div || hit_dat);
  assign user_valid  = cpu_valid && in_user;
  assign sink_hit    = cpu_valid && ((flash_win && is_wr) ||
                                     (in_regs && !hit_cfg && !hit_div && !hit_dat));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sink_ack_q <= 1'b0;
    else        sink_ack_q <= sink_hit && !sink_ack_q;

  assign cpu_ready = (sram_valid && sram_ready) || (flash_valid && flash_ready) ||
                     (cfg_valid && cfg_ready) || (uart_valid && uart_ready) ||
                     (user_valid && user_ready) || (sink_hit && sink_ack_q);

  always_comb begin
    cpu_rdata = '0;
    if (sram_valid)       cpu_rdata = sram_rdata;
    else if (flash_valid) cpu_rdata = flash_rdata;
    else if (cfg_valid)   cpu_rdata = cfg_rdata;
    else if (uart_valid)  cpu_rdata = uart_rdata;
    else if (user_valid)  cpu_rdata = user_rdata;
  end

  a_r8_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sram_valid, flash_valid, cfg_valid, uart_valid, user_valid, sink_hit}));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_valid |-> !cpu_ready);

  a_r4_sink_answer: assert property (@(posedge clk) disable iff (!rst_n)
    (sink_hit && !sink_ack_q && cpu_valid) |=> (cpu_ready || !cpu_valid));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sink_ack_q |=> !sink_ack_q);

  a_r2_overlay_split: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && in_low && !is_wr) |-> (sram_valid ^ flash_valid));

endmodule

// File: tb/test_soc_bus_router.sv
module test_soc_bus_router;
  localparam int T_SRAM = 0, T_FLASH = 1, T_CFG = 2, T_UART = 3, T_USER = 4, T_NONE = 5;

  typedef struct {
    int          tgt;
    logic [31:0] rdata;
    logic [31:0] sub;
    int          lat;
    string       req;
  } exp_t;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic        cpu_valid = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic [3:0]  cpu_wstrb = 0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata, tgt_wdata;
  logic [3:0]  tgt_wstrb;
  logic        sram_valid, flash_valid, cfg_valid, uart_valid, user_valid, uart_data_sel;
  logic [7:0]  sram_word;
  logic [23:0] flash_offset;
  logic [31:0] user_addr;
  logic [4:0]  rq;
  logic        junk = 0;

  always_ff @(posedge clk)
    rq <= {user_valid, uart_valid, cfg_valid, flash_valid, sram_valid} & ~rq;

  soc_bus_router i_soc_bus_router (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_wstrb(cpu_wstrb), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .tgt_wdata(tgt_wdata), .tgt_wstrb(tgt_wstrb),
    .sram_valid(sram_valid), .sram_word(sram_word), .sram_ready(rq[0] | junk),
    .sram_rdata(32'hA000_0000 ^ cpu_addr),
    .flash_valid(flash_valid), .flash_offset(flash_offset), .flash_ready(rq[1] | junk),
    .flash_rdata(32'hB000_0000 ^ cpu_addr),
    .cfg_valid(cfg_valid), .cfg_ready(rq[2] | junk), .cfg_rdata(32'hC000_0000 ^ cpu_addr),
    .uart_valid(uart_valid), .uart_data_sel(uart_data_sel), .uart_ready(rq[3] | junk),
    .uart_rdata(32'hD000_0000 ^ cpu_addr),
    .user_valid(user_valid), .user_addr(user_addr), .user_ready(rq[4] | junk),
    .user_rdata(32'hE000_0000 ^ cpu_addr)
  );

  int checks = 0, failures = 0, served = 0, lat_cnt = 0;
  exp_t exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] sig(input int t, input logic [31:0] a);
    case (t)
      T_SRAM:  return 32'hA000_0000 ^ a;
      T_FLASH: return 32'hB000_0000 ^ a;
      T_CFG:   return 32'hC000_0000 ^ a;
      T_UART:  return 32'hD000_0000 ^ a;
      T_USER:  return 32'hE000_0000 ^ a;
      default: return 32'h0;
    endcase
  endfunction

  task automatic access(input logic [31:0] a, input logic [3:0] s, input int t,
                        input logic [31:0] sub, input int lat, input string req);
    int target;
    exp_t e;
    e.tgt = t; e.rdata = sig(t, a); e.sub = sub; e.lat = lat; e.req = req;
    exp_q.push_back(e);
    target = served + 1;
    @(posedge clk); #1;
    cpu_valid = 1; cpu_addr = a; cpu_wstrb = s; cpu_wdata = ~a;
    wait (served == target);
    @(posedge clk); #1;
    cpu_valid = 0; cpu_wstrb = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && cpu_valid) begin
      lat_cnt++;
      if (cpu_ready) begin
        exp_t e;
        int obs;
        logic [31:0] osub;
        e = exp_q.pop_front();
        case ({user_valid, uart_valid, cfg_valid, flash_valid, sram_valid})
          5'b00001: begin obs = T_SRAM;  osub = 32'(sram_word); end
          5'b00010: begin obs = T_FLASH; osub = 32'(flash_offset); end
          5'b00100: begin obs = T_CFG;   osub = 0; end
          5'b01000: begin obs = T_UART;  osub = 32'(uart_data_sel); end
          5'b10000: begin obs = T_USER;  osub = user_addr; end
          5'b00000: begin obs = T_NONE;  osub = 0; end
          default:  begin obs = 7;       osub = 0; end
        endcase
        chk(obs == e.tgt, e.req, "target", obs, e.tgt);
        chk(osub == e.sub, e.req, "target field", osub, e.sub);
        chk(cpu_rdata == e.rdata, "R9", "read data", cpu_rdata, e.rdata);
        chk(lat_cnt == e.lat, e.req, "latency", lat_cnt, e.lat);
        chk(tgt_wstrb == cpu_wstrb, "R1", "strobe pass", tgt_wstrb, cpu_wstrb);
        lat_cnt = 0;
        served++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R8 watchdog expired actual=%0d expected=%0d", served, exp_q.size());
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(cpu_ready == 0, "R10", "ready after reset", cpu_ready, 0);
    chk({sram_valid, flash_valid, cfg_valid, uart_valid, user_valid} == 0, "R10",
        "valids after reset", {sram_valid, flash_valid, cfg_valid, uart_valid, user_valid}, 0);

    access(32'h0000_0000, 4'hF, T_SRAM, 0, 2, "R1");
    access(32'h0000_03FC, 4'h0, T_SRAM, 255, 2, "R1");
    access(32'h0000_0400, 4'h0, T_FLASH, 32'h400, 2, "R2");
    access(32'h0010_0000, 4'h0, T_FLASH, 32'h10_0000, 2, "R2");
    access(32'h0100_0400, 4'h0, T_FLASH, 32'h400, 2, "R3");
    access(32'h01FF_FFFC, 4'h0, T_FLASH, 32'hFF_FFFC, 2, "R3");
    access(32'h0100_0000, 4'hF, T_NONE, 0, 2, "R4");
    access(32'h0000_0800, 4'h3, T_NONE, 0, 2, "R4");
    access(32'h0200_0000, 4'h0, T_CFG, 0, 2, "R5");
    access(32'h0200_0004, 4'hF, T_UART, 0, 2, "R5");
    access(32'h0200_0008, 4'h0, T_UART, 1, 2, "R5");
    access(32'h0200_000C, 4'h0, T_NONE, 0, 2, "R6");
    access(32'h02FF_FFF0, 4'hF, T_NONE, 0, 2, "R6");
    access(32'h0300_0000, 4'h0, T_USER, 32'h0300_0000, 2, "R7");
    access(32'hFFFF_FFFC, 4'hF, T_USER, 32'hFFFF_FFFC, 2, "R7");

    junk = 1;
    access(32'h0000_0010, 4'h0, T_SRAM, 4, 1, "R8");
    access(32'h0200_0010, 4'h0, T_NONE, 0, 2, "R8");
    access(32'h0100_0020, 4'hF, T_NONE, 0, 2, "R8");
    junk = 0;

    repeat (2) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule